// File: doc/BRIEF.md
# Interrupt Security Target Filter

This block keeps one security-target bit for every external interrupt. It also keeps simple enable, pending, active and priority state for those interrupts. A single register bus reaches all of this state. Each access carries a flag that says whether it is secure. A secure access sees every field. A non-secure access sees only the fields of interrupts whose target bit selects the non-secure state. Every other field reads as zero and ignores the write. The target bits themselves are visible only to secure accesses.

Bus writes take effect at the clock edge where `req` and `we` are both high. Reads are combinational and valid in the same cycle. Hardware inputs let a neighbouring controller raise pending bits and raise or drop active bits. The stored state is also driven out on flat vectors for the arbitration logic that sits beside this block. A build-time option selects a reduced configuration: at most 32 interrupts, 2 priority bits, and a reserved active view.

Top module: `itf_sec_filter`

## Requirements
- R1: After reset every target bit is 0 (all interrupts secure), and all enable, pending, active and priority state is zero.
- R2: Word addresses 0x00+k hold the target bits of interrupts 32k..32k+31, where bit b belongs to interrupt 32k+b; 1 selects non-secure and 0 selects secure. Secure accesses read and write these words. Non-secure accesses read zero and their writes are ignored. `tgt_ns_o` shows the stored bits.
- R3: Writing ones to set-enable word 0x08+k sets the matching enable bits, and writing ones to clear-enable word 0x10+k clears them. Zero bits have no effect. Both words read the current enable state.
- R4: On a non-secure access, the enable, pending and active bits of secure-targeted interrupts read as zero and ignore writes. Bits of non-secure-targeted interrupts behave exactly as they do for a secure access.
- R5: Set-pending word 0x18+k and clear-pending word 0x20+k follow the R3 rules for pending state. A high `hw_pend_set` bit sets that pending bit, and it wins over a clear written in the same cycle.
- R6: Active word 0x28+k is a read-only view, so bus writes to it change nothing. `hw_act_set` sets an active bit and `hw_act_clr` clears it; if both are high, set wins.
- R7: Priority word 0x40+m holds one byte per interrupt, with bits 8j+7..8j belonging to interrupt 4m+j. Only the upper PW bits of each byte are stored, and the lower bits read zero. A non-secure access to the byte of a secure-targeted interrupt reads zero and ignores the write.
- R8: The following all read zero, and writes to them change nothing: bits and bytes of interrupt numbers at or above NUM_IRQ, and addresses outside the regions above. `rdata` is zero whenever no read is requested.
- R9: With MINIMAL set, PW is 2 and the active words read zero. NUM_IRQ above 32 is rejected at elaboration.
- R10: The output vectors always match the stored state. A write becomes visible on them in the cycle after its clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Access request |
| we | input | 1 | 1 = write, 0 = read |
| addr | input | 8 | Word address |
| wdata | input | 32 | Write data |
| sec | input | 1 | 1 = secure access |
| rdata | output | 32 | Read data, combinational |
| hw_pend_set | input | NUM_IRQ | Hardware pending set |
| hw_act_set | input | NUM_IRQ | Hardware active set |
| hw_act_clr | input | NUM_IRQ | Hardware active clear |
| tgt_ns_o | output | NUM_IRQ | Target state, 1 = non-secure |
| en_o | output | NUM_IRQ | Enable state |
| pend_o | output | NUM_IRQ | Pending state |
| act_o | output | NUM_IRQ | Active state |
| prio_o | output | NUM_IRQ*8 | Priority bytes, interrupt i at bits 8i+7..8i |

## Verification
Several properties are checked on every cycle:
- A bit or byte whose access is blocked keeps its value through any write.
- A hardware pending set always lands, even against a clear.
- A clear write empties its bit.
- Target and unmapped reads return zero for non-secure accesses.
- In the reduced build, the active view reads zero.

Other behaviour only the bench scenarios can show:
- That the masking tracks target bits that change during the run.
- That the priority bytes line up with the right interrupts.
- That partial words above NUM_IRQ stay empty.
- That the reduced build truncates priorities to two bits.

// File: rtl/itf_pkg.sv
package itf_pkg;
   localparam int WORD_W    = 32;
   localparam int MAX_WORDS = 8;
   localparam int MAX_IRQ   = WORD_W * MAX_WORDS;
   localparam int ADDR_W    = 8;

   // bank update styles
   localparam int BB_PLAIN  = 0;
   localparam int BB_SETCLR = 1;
   localparam int BB_HWONLY = 2;

   typedef enum logic [2:0] {
      RG_TGT, RG_SETEN, RG_CLREN, RG_SETPD, RG_CLRPD, RG_ACT, RG_PRIO, RG_NONE
   } region_e;

   typedef struct packed {
      region_e    region;
      logic [2:0] widx;
      logic [5:0] pidx;
   } dec_t;
endpackage

// File: rtl/itf_decode.sv
module itf_decode
   import itf_pkg::*;
(
   input  logic [ADDR_W-1:0] addr,
   output dec_t              dec
);
   always_comb begin
      dec.widx   = addr[2:0];
      dec.pidx   = addr[5:0];
      dec.region = RG_NONE;
      if (addr[7:6] == 2'b01) begin
         dec.region = RG_PRIO;
      end else if (addr[7:6] == 2'b00) begin
         case (addr[5:3])
            3'd0:    dec.region = RG_TGT;
            3'd1:    dec.region = RG_SETEN;
            3'd2:    dec.region = RG_CLREN;
            3'd3:    dec.region = RG_SETPD;
            3'd4:    dec.region = RG_CLRPD;
            3'd5:    dec.region = RG_ACT;
            default: dec.region = RG_NONE;
         endcase
      end
   end
endmodule

// File: rtl/itf_bitbank.sv
module itf_bitbank
   import itf_pkg::*;
#(
   parameter int N    = 48,
   parameter int MODE = BB_SETCLR
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_plain,
   input  logic              wr_set,
   input  logic              wr_clr,
   input  logic [2:0]        widx,
   input  logic [WORD_W-1:0] wdata,
   input  logic [N-1:0]      allow,
   input  logic [N-1:0]      hw_set,
   input  logic [N-1:0]      hw_clr,
   output logic [N-1:0]      st
);
   logic [N-1:0] nxt;
   logic         unused_in;
   assign unused_in = ^{wr_plain, wr_set, wr_clr, widx, wdata, allow, hw_set, hw_clr};

   if (MODE < BB_PLAIN || MODE > BB_HWONLY) begin : g_bad_mode
      $error("itf_bitbank: MODE out of range");
   end
   if (N < 1 || N > MAX_IRQ) begin : g_bad_n
      $error("itf_bitbank: N out of range");
   end

   for (genvar i = 0; i < N; i++) begin : g_bit
      localparam int W = i / WORD_W;
      localparam int B = i % WORD_W;
      if (MODE == BB_PLAIN) begin : g_plain
         logic hit;
         assign hit    = wr_plain && (widx == 3'(W)) && allow[i];
         assign nxt[i] = hit ? wdata[B] : st[i];
      end else if (MODE == BB_SETCLR) begin : g_setclr
         logic sset, sclr;
         assign sset   = wr_set && (widx == 3'(W)) && allow[i] && wdata[B];
         assign sclr   = wr_clr && (widx == 3'(W)) && allow[i] && wdata[B];
         assign nxt[i] = (st[i] & ~sclr & ~hw_clr[i]) | sset | hw_set[i];
         // a clear with no competing set must empty the bit (R3)
         p_clear_empties_r3: assert property (@(posedge clk) disable iff (!rst_n)
            (sclr && !hw_set[i] && !wr_set) |=> !st[i]);
         // hardware set always lands (R5)
         p_hw_set_lands_r5: assert property (@(posedge clk) disable iff (!rst_n)
            hw_set[i] |=> st[i]);
      end else begin : g_hwonly
         assign nxt[i] = (st[i] & ~hw_clr[i]) | hw_set[i];
         // set wins over clear (R6)
         p_act_set_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
            hw_set[i] |=> st[i]);
      end
      // blocked bit with no hardware event keeps its value (R4)
      p_masked_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
         (!allow[i] && !hw_set[i] && !hw_clr[i]) |=> $stable(st[i]));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st <= '0;
      else        st <= nxt;
   end
endmodule

// File: rtl/itf_prio_bank.sv
module itf_prio_bank
   import itf_pkg::*;
#(
   parameter int N  = 48,
   parameter int PW = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr,
   input  logic [5:0]        pidx,
   input  logic [WORD_W-1:0] wdata,
   input  logic [N-1:0]      allow,
   output logic [N*8-1:0]    prio_flat
);
   localparam int PAD = 8 - PW;

   if (PW < 1 || PW > 8) begin : g_bad_pw
      $error("itf_prio_bank: PW must be 1..8");
   end

   logic [N-1:0][PW-1:0] pr, nxt;

   for (genvar i = 0; i < N; i++) begin : g_irq
      localparam int M = i / 4;
      localparam int J = i % 4;
      logic hit;
      assign hit    = wr && (pidx == 6'(M)) && allow[i];
      assign nxt[i] = hit ? wdata[J*8+7 -: PW] : pr[i];
      if (PW == 8) begin : g_full
         assign prio_flat[i*8 +: 8] = pr[i];
      end else begin : g_trunc
         assign prio_flat[i*8 +: 8] = {pr[i], {PAD{1'b0}}};
      end
      // a blocked byte never changes (R7)
      p_prio_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
         !allow[i] |=> $stable(pr[i]));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pr <= '0;
      else        pr <= nxt;
   end
endmodule

// File: rtl/itf_sec_filter.sv
module itf_sec_filter
   import itf_pkg::*;
#(
   parameter int NUM_IRQ   = 48,
   parameter int PRIO_BITS = 3,
   parameter bit MINIMAL   = 1'b0
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 req,
   input  logic                 we,
   input  logic [7:0]           addr,
   input  logic [31:0]          wdata,
   input  logic                 sec,
   output logic [31:0]          rdata,
   input  logic [NUM_IRQ-1:0]   hw_pend_set,
   input  logic [NUM_IRQ-1:0]   hw_act_set,
   input  logic [NUM_IRQ-1:0]   hw_act_clr,
   output logic [NUM_IRQ-1:0]   tgt_ns_o,
   output logic [NUM_IRQ-1:0]   en_o,
   output logic [NUM_IRQ-1:0]   pend_o,
   output logic [NUM_IRQ-1:0]   act_o,
   output logic [NUM_IRQ*8-1:0] prio_o
);
   localparam int PW = MINIMAL ? 2 : PRIO_BITS;

   if (NUM_IRQ < 1 || NUM_IRQ > MAX_IRQ) begin : g_bad_n
      $error("itf_sec_filter: NUM_IRQ out of range");
   end
   if (MINIMAL && NUM_IRQ > 32) begin : g_bad_min
      $error("itf_sec_filter: reduced build allows at most 32 interrupts");
   end
   if (PW < 1 || PW > 8) begin : g_bad_pw
      $error("itf_sec_filter: PRIO_BITS must be 1..8");
   end

   dec_t dec;
   itf_decode u_dec (.addr(addr), .dec(dec));

   logic               wr;
   logic [NUM_IRQ-1:0] allow_irq, allow_tgt, zero_v;
   assign wr        = req && we;
   assign allow_irq = sec ? {NUM_IRQ{1'b1}} : tgt_ns_o;
   assign allow_tgt = {NUM_IRQ{sec}};
   assign zero_v    = '0;

   itf_bitbank #(.N(NUM_IRQ), .MODE(BB_PLAIN)) u_tgt (
      .clk(clk), .rst_n(rst_n),
      .wr_plain(wr && dec.region == RG_TGT), .wr_set(1'b0), .wr_clr(1'b0),
      .widx(dec.widx), .wdata(wdata), .allow(allow_tgt),
      .hw_set(zero_v), .hw_clr(zero_v), .st(tgt_ns_o));

   itf_bitbank #(.N(NUM_IRQ), .MODE(BB_SETCLR)) u_en (
      .clk(clk), .rst_n(rst_n),
      .wr_plain(1'b0), .wr_set(wr && dec.region == RG_SETEN),
      .wr_clr(wr && dec.region == RG_CLREN),
      .widx(dec.widx), .wdata(wdata), .allow(allow_irq),
      .hw_set(zero_v), .hw_clr(zero_v), .st(en_o));

   itf_bitbank #(.N(NUM_IRQ), .MODE(BB_SETCLR)) u_pend (
      .clk(clk), .rst_n(rst_n),
      .wr_plain(1'b0), .wr_set(wr && dec.region == RG_SETPD),
      .wr_clr(wr && dec.region == RG_CLRPD),
      .widx(dec.widx), .wdata(wdata), .allow(allow_irq),
      .hw_set(hw_pend_set), .hw_clr(zero_v), .st(pend_o));

   itf_bitbank #(.N(NUM_IRQ), .MODE(BB_HWONLY)) u_act (
      .clk(clk), .rst_n(rst_n),
      .wr_plain(1'b0), .wr_set(1'b0), .wr_clr(1'b0),
      .widx(dec.widx), .wdata(wdata), .allow(allow_irq),
      .hw_set(hw_act_set), .hw_clr(hw_act_clr), .st(act_o));

   itf_prio_bank #(.N(NUM_IRQ), .PW(PW)) u_prio (
      .clk(clk), .rst_n(rst_n),
      .wr(wr && dec.region == RG_PRIO), .pidx(dec.pidx), .wdata(wdata),
      .allow(allow_irq), .prio_flat(prio_o));

   // zero-padded views for the read path
   logic [MAX_IRQ-1:0]   tgt_pad, en_pad, pd_pad, act_pad;
   logic [MAX_IRQ*8-1:0] prio_pad;
   always_comb begin
      tgt_pad = '0; en_pad = '0; pd_pad = '0; act_pad = '0; prio_pad = '0;
      tgt_pad[NUM_IRQ-1:0]    = tgt_ns_o;
      en_pad[NUM_IRQ-1:0]     = en_o;
      pd_pad[NUM_IRQ-1:0]     = pend_o;
      act_pad[NUM_IRQ-1:0]    = act_o;
      prio_pad[NUM_IRQ*8-1:0] = prio_o;
   end

   logic [31:0] wmask, bmask, act_word, rd;
   assign wmask = sec ? 32'hFFFF_FFFF : tgt_pad[{dec.widx, 5'd0} +: 32];
   for (genvar j = 0; j < 4; j++) begin : g_bmask
      assign bmask[j*8 +: 8] = (sec || tgt_pad[{dec.pidx, 2'(j)}]) ? 8'hFF : 8'h00;
   end

   if (MINIMAL) begin : g_act_rsvd
      assign act_word = '0;
      // reserved active view (R9)
      p_act_reserved_r9: assert property (@(posedge clk) disable iff (!rst_n)
         (req && !we && dec.region == RG_ACT) |-> (rdata == '0));
   end else begin : g_act_full
      assign act_word = act_pad[{dec.widx, 5'd0} +: 32];
   end

   always_comb begin
      case (dec.region)
         RG_TGT:             rd = sec ? tgt_pad[{dec.widx, 5'd0} +: 32] : '0;
         RG_SETEN, RG_CLREN: rd = en_pad[{dec.widx, 5'd0} +: 32] & wmask;
         RG_SETPD, RG_CLRPD: rd = pd_pad[{dec.widx, 5'd0} +: 32] & wmask;
         RG_ACT:             rd = act_word & wmask;
         RG_PRIO:            rd = prio_pad[{dec.pidx, 5'd0} +: 32] & bmask;
         default:            rd = '0;
      endcase
      rdata = (req && !we) ? rd : '0;
   end

   // target words are invisible to non-secure reads (R2)
   p_ns_tgt_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (req && !we && !sec && dec.region == RG_TGT) |-> (rdata == '0));
   // target bits never move on a non-secure cycle (R2)
   p_ns_tgt_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !sec |=> $stable(tgt_ns_o));
   // unmapped space reads zero (R8)
   p_unmapped_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (dec.region == RG_NONE) |-> (rdata == '0));
endmodule

// File: tb/sim_itf_sec_filter.sv
`timescale 1ns/1ps
module sim_itf_sec_filter;
   localparam int N   = 48;
   localparam int PW  = 3;
   localparam logic [7:0] PMASK = 8'hE0;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req = 1'b0, we = 1'b0, sec = 1'b0;
   logic [7:0]  addr = '0;
   logic [31:0] wdata = '0;
   logic [N-1:0] hps = '0, has = '0, hac = '0;
   logic [31:0] rdata, rdata1;
   logic [N-1:0] tgt_o, en_o, pd_o, act_o;
   logic [N*8-1:0] pr_o;
   logic [31:0] t1, e1, p1, a1;
   logic [255:0] pr1;

   int checks = 0, errors = 0;
   bit done = 0;

   always #10 clk = ~clk;

   itf_sec_filter #(.NUM_IRQ(N), .PRIO_BITS(PW), .MINIMAL(1'b0)) u0 (
      .clk(clk), .rst_n(rst_n), .req(req), .we(we), .addr(addr), .wdata(wdata),
      .sec(sec), .rdata(rdata), .hw_pend_set(hps), .hw_act_set(has), .hw_act_clr(hac),
      .tgt_ns_o(tgt_o), .en_o(en_o), .pend_o(pd_o), .act_o(act_o), .prio_o(pr_o));

   itf_sec_filter #(.NUM_IRQ(32), .PRIO_BITS(8), .MINIMAL(1'b1)) u1 (
      .clk(clk), .rst_n(rst_n), .req(req), .we(we), .addr(addr), .wdata(wdata),
      .sec(sec), .rdata(rdata1), .hw_pend_set(hps[31:0]), .hw_act_set(has[31:0]),
      .hw_act_clr(hac[31:0]), .tgt_ns_o(t1), .en_o(e1), .pend_o(p1), .act_o(a1),
      .prio_o(pr1));

   // ---------------- reference model ----------------
   bit       m_tgt[N], m_en[N], m_pd[N], m_act[N];
   bit [7:0] m_pr[N];

   always @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < N; i++) begin
            m_tgt[i] = 0; m_en[i] = 0; m_pd[i] = 0; m_act[i] = 0; m_pr[i] = 0;
         end
      end else begin
         bit pre_tgt[N];
         for (int i = 0; i < N; i++) pre_tgt[i] = m_tgt[i];
         if (req && we) begin
            int a; a = addr;
            if (a >= 64 && a < 128) begin
               for (int j = 0; j < 4; j++) begin
                  int i; i = (a - 64) * 4 + j;
                  if (i < N && (sec || pre_tgt[i])) m_pr[i] = wdata[j*8 +: 8] & PMASK;
               end
            end else if (a < 48) begin
               for (int b = 0; b < 32; b++) begin
                  int i; i = (a % 8) * 32 + b;
                  if (i < N) begin
                     bit ok; ok = sec || pre_tgt[i];
                     case (a / 8)
                        0: if (sec) m_tgt[i] = wdata[b];
                        1: if (ok && wdata[b]) m_en[i] = 1;
                        2: if (ok && wdata[b]) m_en[i] = 0;
                        3: if (ok && wdata[b]) m_pd[i] = 1;
                        4: if (ok && wdata[b]) m_pd[i] = 0;
                        default: ;
                     endcase
                  end
               end
            end
         end
         for (int i = 0; i < N; i++) begin
            if (hps[i]) m_pd[i] = 1;
            if (hac[i]) m_act[i] = 0;
            if (has[i]) m_act[i] = 1;
         end
      end
   end

   function automatic logic [31:0] mdl_read(input logic [7:0] a, input logic s);
      logic [31:0] r; r = '0;
      if (a >= 8'h40 && a < 8'h80) begin
         for (int j = 0; j < 4; j++) begin
            int i; i = (int'(a) - 64) * 4 + j;
            if (i < N && (s || m_tgt[i])) r[j*8 +: 8] = m_pr[i];
         end
      end else if (a < 8'h30) begin
         for (int b = 0; b < 32; b++) begin
            int i; i = (int'(a) % 8) * 32 + b;
            if (i < N) begin
               bit ok; ok = s || m_tgt[i];
               case (int'(a) / 8)
                  0:    r[b] = s && m_tgt[i];
                  1, 2: r[b] = ok && m_en[i];
                  3, 4: r[b] = ok && m_pd[i];
                  5:    r[b] = ok && m_act[i];
                  default: ;
               endcase
            end
         end
      end
      return r;
   endfunction

   function automatic string tag_of(input logic [7:0] a, input logic s);
      if (a >= 8'h80 || (a >= 8'h30 && a < 8'h40)) return "R8";
      if (a >= 8'h40) return "R7";
      if (a < 8'h08) return "R2";
      if (!s) return "R4";
      if (a < 8'h18) return "R3";
      if (a < 8'h28) return "R5";
      return "R6";
   endfunction

   task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
      end
   endtask

   // every-cycle comparison of the state vectors (R10)
   always @(negedge clk) begin
      if (rst_n && !done) begin
         bit ok; ok = 1;
         for (int i = 0; i < N; i++) begin
            if (tgt_o[i] !== m_tgt[i] || en_o[i] !== m_en[i] || pd_o[i] !== m_pd[i] ||
                act_o[i] !== m_act[i] || pr_o[i*8 +: 8] !== m_pr[i]) ok = 0;
         end
         chk(ok, "R10 outputs", {16'h0, tgt_o}, 64'h0);
      end
   end

   // ---------------- stimulus ----------------
   task automatic op(input logic [7:0] a, input logic [31:0] d, input logic s, input logic w,
                     input logic [N-1:0] ps, input logic [N-1:0] as, input logic [N-1:0] ac);
      @(negedge clk);
      req = 1; we = w; addr = a; wdata = d; sec = s; hps = ps; has = as; hac = ac;
      #5;
      if (!w) chk(rdata === mdl_read(a, s), tag_of(a, s), {32'h0, rdata}, {32'h0, mdl_read(a, s)});
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d, input logic s);
      op(a, d, s, 1'b1, '0, '0, '0);
   endtask
   task automatic rd(input logic [7:0] a, input logic s);
      op(a, 32'h0, s, 1'b0, '0, '0, '0);
   endtask
   task automatic rd_min(input logic [7:0] a, input logic s, input logic [31:0] exp);
      op(a, 32'h0, s, 1'b0, '0, '0, '0);
      chk(rdata1 === exp, "R9", {32'h0, rdata1}, {32'h0, exp});
   endtask

   initial begin
      #(20 * 150000);
      if (!done) begin
         done = 1;
         errors++; checks++;
         $display("FAIL watchdog expired");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk); #5;
      // R1: reset state
      chk(tgt_o == '0 && en_o == '0 && pd_o == '0 && act_o == '0 && pr_o == '0,
          "R1 reset", {16'h0, tgt_o | en_o | pd_o | act_o}, 64'h0);
      rd(8'h00, 1'b1); rd(8'h08, 1'b1); rd(8'h40, 1'b1);
      // R8: idle read data
      req = 0; #1;
      chk(rdata === '0, "R8 idle", {32'h0, rdata}, 64'h0);

      // R2: target programming
      wr(8'h00, 32'h0000_F0F0, 1'b1);
      wr(8'h01, 32'hFFFF_8001, 1'b1);     // bits above interrupt 47 dropped (R8)
      wr(8'h00, 32'hFFFF_FFFF, 1'b0);     // non-secure write ignored
      rd(8'h00, 1'b0); rd(8'h00, 1'b1); rd(8'h01, 1'b1);

      // R3/R4: enable
      wr(8'h08, 32'hFFFF_FFFF, 1'b0);
      rd(8'h08, 1'b0); rd(8'h08, 1'b1);
      wr(8'h09, 32'hFFFF_FFFF, 1'b1);
      wr(8'h08, 32'hFFFF_FFFF, 1'b1);
      wr(8'h10, 32'hFFFF_FFFF, 1'b0);
      rd(8'h10, 1'b1); rd(8'h09, 1'b0);
      wr(8'h10, 32'h0000_000F, 1'b1);
      rd(8'h08, 1'b1);

      // R5: pending with hardware set beating a clear
      wr(8'h18, 32'h0000_00FF, 1'b1);
      op(8'h20, 32'h0000_00FF, 1'b1, 1'b1, 48'h0000_0000_0003, '0, '0);
      rd(8'h18, 1'b1);
      chk(pd_o[1:0] == 2'b11 && pd_o[7:2] == '0, "R5 hw wins", {56'h0, pd_o[7:0]}, 64'h3);
      wr(8'h19, 32'h0000_FFFF, 1'b0);
      rd(8'h19, 1'b0); rd(8'h21, 1'b1);

      // R6: active is hardware-driven only
      op(8'h28, 32'h0, 1'b1, 1'b0, '0, 48'h8001_0000_1010, '0);
      op(8'h00, 32'h0000_F0F0, 1'b1, 1'b1, '0, 48'h0000_0000_0100, 48'h0000_0000_0110);
      wr(8'h28, 32'h0, 1'b1);
      rd(8'h28, 1'b1); rd(8'h28, 1'b0); rd(8'h29, 1'b0);
      chk(act_o[8] == 1'b1 && act_o[4] == 1'b0, "R6 set wins", {63'h0, act_o[8]}, 64'h1);

      // R7: priorities
      wr(8'h40, 32'hFFFF_FFFF, 1'b1);
      wr(8'h41, 32'h1234_5678, 1'b0);     // interrupts 4..7 are NS-targeted
      wr(8'h43, 32'hA5A5_A5A5, 1'b0);     // interrupts 12..15 are NS-targeted
      wr(8'h42, 32'hFFFF_FFFF, 1'b0);     // secure-targeted, ignored
      rd(8'h40, 1'b0); rd(8'h40, 1'b1); rd(8'h41, 1'b0); rd(8'h43, 1'b0); rd(8'h42, 1'b0);

      // R8: out of range
      wr(8'h4C, 32'hFFFF_FFFF, 1'b1);
      rd(8'h4C, 1'b1); rd(8'h30, 1'b1); rd(8'h02, 1'b1); rd(8'h9F, 1'b1); rd(8'h0A, 1'b1);

      // R9: reduced build
      rd_min(8'h40, 1'b1, 32'hC0C0_C0C0);
      rd_min(8'h28, 1'b1, 32'h0);
      rd_min(8'h09, 1'b1, 32'h0);

      // randomised traffic against the model
      for (int k = 0; k < 600; k++) begin
         logic [7:0] a;
         logic [N-1:0] ps, as, ac;
         a  = 8'($urandom_range(0, 135));
         ps = {$urandom, $urandom} & {$urandom, $urandom} & {$urandom, $urandom};
         as = {$urandom, $urandom} & {$urandom, $urandom} & {$urandom, $urandom};
         ac = {$urandom, $urandom} & {$urandom, $urandom};
         op(a, $urandom, 1'($urandom), 1'($urandom), ps, as, ac);
      end

      @(negedge clk);
      req = 0; hps = '0; has = '0; hac = '0;
      repeat (2) @(negedge clk);
      if (!done) begin
         done = 1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule